// File: doc/BRIEF.md
# Diagnostic evidence accumulator and ranker

This block scores candidate stuck-at faults while a failing device is being diagnosed. For every test pattern, the caller supplies two failing-output vectors. One comes from the device under diagnosis. The other comes from a reference machine into which the candidate fault has been injected. Each pattern is one beat. The block counts the outputs on which the two vectors agree and disagree, and it sums these counts over the test set into an evidence tuple of four fields: sigma, iota, tau and gamma.

Candidates arrive one after another. The beats of a candidate are followed by an end marker that carries the candidate's identifier. The end marker may also carry that candidate's final beat. At each end marker the finished tuple is ranked against the best tuple held so far, and the winner's identifier and tuple are kept. A flag on the end marker closes the candidate set. One cycle later the block pulses its result outputs with the top-ranked candidate, and the next end marker begins a new set.

Top module: `evidence_ranker`

## Requirements
- R1: sigma is the sum, over the candidate's beats, of the number of output bits set in both `dut_fail` and `ref_fail`.
- R2: iota is the sum of the number of bits set in `ref_fail` and clear in `dut_fail`.
- R3: tau is the sum of the number of bits set in `dut_fail` and clear in `ref_fail`.
- R4: gamma is the sum, over beats, of the larger of that beat's iota count and tau count.
- R5: Each of the four sums saturates at 2^ACC_W-1 and stays there until the candidate ends.
- R6: The candidate with the lowest gamma ranks first.
- R7: Among candidates with equal gamma, the highest sigma ranks first.
- R8: Among candidates with equal gamma and equal sigma, the lowest iota ranks first.
- R9: When gamma, sigma and iota are all equal, the candidate that ended earlier keeps the top rank.
- R10: `res_valid` is high for exactly the one cycle that follows an end marker with `cand_last` set, and it is low otherwise. During that cycle, `res_id` and the `res_*` fields give the top-ranked candidate of the set.
- R11: A beat presented in the same cycle as an end marker counts toward the candidate that is ending. The next candidate's sums start from zero.
- R12: After a set closes, the first candidate of the next set is taken as the best, whatever its tuple.
- R13: After reset, `res_valid`, `res_id` and all result fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | A pattern beat is present |
| dut_fail | input | NOUT | Failing outputs observed on the device for this pattern |
| ref_fail | input | NOUT | Failing outputs of the fault-injected reference machine |
| cand_end | input | 1 | End marker of the current candidate |
| cand_id | input | ID_W | Identifier of the ending candidate |
| cand_last | input | 1 | With `cand_end`: the candidate is the last of the set |
| res_valid | output | 1 | Result pulse |
| res_id | output | ID_W | Identifier of the top-ranked candidate |
| res_sigma | output | ACC_W | sigma of that candidate |
| res_iota | output | ACC_W | iota of that candidate |
| res_tau | output | ACC_W | tau of that candidate |
| res_gamma | output | ACC_W | gamma of that candidate |

## Verification
The bench builds the block with NOUT=8, ACC_W=6 and ID_W=8. With these values a beat contributes at most 8 to a sum, so ten beats on which every output fails in both vectors drive sigma past 63, and the saturation of R5 is reached in a few cycles. The 8-bit vectors are small enough for each ranking key (gamma, then sigma, then iota) to be set up as a tie or a win by hand, so R6 to R9 are each exercised on their own.

// File: rtl/evidence_pkg.sv
package evidence_pkg;

    localparam int unsigned NF     = 4;
    localparam int unsigned IX_SIG = 0;
    localparam int unsigned IX_IOT = 1;
    localparam int unsigned IX_TAU = 2;
    localparam int unsigned IX_GAM = 3;

    typedef enum logic [1:0] {
        CMP_LOSE  = 2'd0,
        CMP_GAMMA = 2'd1,
        CMP_SIGMA = 2'd2,
        CMP_IOTA  = 2'd3
    } cmp_e;

    // Three-key ranking: gamma ascending, sigma descending, iota ascending.
    // A full tie loses, so the holder of the rank stays.
    function automatic cmp_e rank_cmp(
        input logic [31:0] g_new,
        input logic [31:0] s_new,
        input logic [31:0] i_new,
        input logic [31:0] g_old,
        input logic [31:0] s_old,
        input logic [31:0] i_old
    );
        if (g_new < g_old)
            return CMP_GAMMA;
        else if (g_new == g_old && s_new > s_old)
            return CMP_SIGMA;
        else if (g_new == g_old && s_new == s_old && i_new < i_old)
            return CMP_IOTA;
        else
            return CMP_LOSE;
    endfunction

endpackage

// File: rtl/evidence_beat_count.sv
module evidence_beat_count
    import evidence_pkg::*;
#(
    parameter int unsigned NOUT  = 16,
    parameter int unsigned CNT_W = $clog2(NOUT + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NOUT-1:0]               dut_fail,
    input  logic [NOUT-1:0]               ref_fail,
    output logic [NF-1:0][CNT_W-1:0]      beat_cnt
);

    logic [NOUT-1:0]  both_v, ref_only_v, dut_only_v;
    logic [CNT_W-1:0] n_sig, n_iot, n_tau, n_gam;

    assign both_v     = dut_fail & ref_fail;
    assign ref_only_v = ref_fail & ~dut_fail;
    assign dut_only_v = dut_fail & ~ref_fail;

    always_comb begin
        n_sig = '0;
        n_iot = '0;
        n_tau = '0;
        for (int k = 0; k < int'(NOUT); k++) begin
            n_sig = n_sig + CNT_W'(both_v[k]);
            n_iot = n_iot + CNT_W'(ref_only_v[k]);
            n_tau = n_tau + CNT_W'(dut_only_v[k]);
        end
        n_gam = (n_iot > n_tau) ? n_iot : n_tau;
    end

    always_comb begin
        beat_cnt         = '0;
        beat_cnt[IX_SIG] = n_sig;
        beat_cnt[IX_IOT] = n_iot;
        beat_cnt[IX_TAU] = n_tau;
        beat_cnt[IX_GAM] = n_gam;
    end

    // R1 R2 R3: the three classes partition the outputs, so never exceed NOUT
    p_partition_r1: assert property (@(posedge clk) disable iff (rst)
        int'(beat_cnt[IX_SIG]) + int'(beat_cnt[IX_IOT]) + int'(beat_cnt[IX_TAU]) <= int'(NOUT));

    // R4: the max term equals one of its operands and bounds both
    p_gamma_max_r4: assert property (@(posedge clk) disable iff (rst)
        beat_cnt[IX_GAM] >= beat_cnt[IX_IOT] && beat_cnt[IX_GAM] >= beat_cnt[IX_TAU] &&
        (beat_cnt[IX_GAM] == beat_cnt[IX_IOT] || beat_cnt[IX_GAM] == beat_cnt[IX_TAU]));

endmodule

// File: rtl/evidence_accum.sv
module evidence_accum
    import evidence_pkg::*;
#(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned ACC_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          beat_valid,
    input  logic                          cand_end,
    input  logic [NF-1:0][CNT_W-1:0]      beat_cnt,
    output logic [NF-1:0][ACC_W-1:0]      cand_tuple
);

    logic [NF-1:0][ACC_W-1:0] acc_q;
    logic [NF-1:0][ACC_W-1:0] acc_sat;

    for (genvar f = 0; f < int'(NF); f++) begin : g_field
        logic [ACC_W:0] sum_ext;

        assign sum_ext    = {1'b0, acc_q[f]} + (ACC_W + 1)'(beat_cnt[f]);
        assign acc_sat[f] = sum_ext[ACC_W] ? {ACC_W{1'b1}} : sum_ext[ACC_W-1:0];
        // final tuple includes a beat arriving with the end marker
        assign cand_tuple[f] = beat_valid ? acc_sat[f] : acc_q[f];

        always_ff @(posedge clk) begin
            if (rst || cand_end)
                acc_q[f] <= '0;
            else if (beat_valid)
                acc_q[f] <= acc_sat[f];
        end

        // R5: within a candidate a sum never falls (no wrap)
        p_acc_monotone_r5: assert property (@(posedge clk) disable iff (rst)
            !$past(cand_end) |-> acc_q[f] >= $past(acc_q[f]));

        // R5: a saturated sum stays at full scale until the candidate ends
        p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (&acc_q[f]) && !cand_end |=> (&acc_q[f]));

        // R11: a sum is zero right after an end marker
        p_restart_r11: assert property (@(posedge clk) disable iff (rst)
            cand_end |=> acc_q[f] == '0);
    end

endmodule

// File: rtl/evidence_select.sv
module evidence_select
    import evidence_pkg::*;
#(
    parameter int unsigned ACC_W = 16,
    parameter int unsigned ID_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cand_end,
    input  logic                          cand_last,
    input  logic [ID_W-1:0]               cand_id,
    input  logic [NF-1:0][ACC_W-1:0]      cand_tuple,
    output logic                          res_valid,
    output logic [ID_W-1:0]               best_id,
    output logic [NF-1:0][ACC_W-1:0]      best_tuple
);

    logic have_q;
    cmp_e cmp;
    logic win;

    always_comb begin
        cmp = rank_cmp(32'(cand_tuple[IX_GAM]), 32'(cand_tuple[IX_SIG]), 32'(cand_tuple[IX_IOT]),
                       32'(best_tuple[IX_GAM]), 32'(best_tuple[IX_SIG]), 32'(best_tuple[IX_IOT]));
        win = !have_q || (cmp != CMP_LOSE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q     <= 1'b0;
            res_valid  <= 1'b0;
            best_id    <= '0;
            best_tuple <= '0;
        end else begin
            res_valid <= cand_end && cand_last;
            if (cand_end) begin
                have_q <= !cand_last;
                if (win) begin
                    best_id    <= cand_id;
                    best_tuple <= cand_tuple;
                end
            end
        end
    end

    // R9: a losing or tying candidate leaves the held rank untouched
    p_keep_on_loss_r9: assert property (@(posedge clk) disable iff (rst)
        cand_end && have_q && !win |=> $stable(best_id) && $stable(best_tuple));

    // R6: inside a set the held gamma never gets worse
    p_gamma_never_worse_r6: assert property (@(posedge clk) disable iff (rst)
        cand_end && have_q |=> best_tuple[IX_GAM] <= $past(best_tuple[IX_GAM]));

    // R10: the result pulse follows a closing end marker
    p_valid_after_last_r10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(cand_end && cand_last));

    // R12: the first candidate of a set is always taken
    p_fresh_load_r12: assert property (@(posedge clk) disable iff (rst)
        cand_end && !have_q |=> best_id == $past(cand_id));

endmodule

// File: rtl/evidence_ranker.sv
module evidence_ranker
    import evidence_pkg::*;
#(
    parameter int unsigned NOUT  = 16,
    parameter int unsigned ACC_W = 16,
    parameter int unsigned ID_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_valid,
    input  logic [NOUT-1:0]  dut_fail,
    input  logic [NOUT-1:0]  ref_fail,
    input  logic             cand_end,
    input  logic [ID_W-1:0]  cand_id,
    input  logic             cand_last,
    output logic             res_valid,
    output logic [ID_W-1:0]  res_id,
    output logic [ACC_W-1:0] res_sigma,
    output logic [ACC_W-1:0] res_iota,
    output logic [ACC_W-1:0] res_tau,
    output logic [ACC_W-1:0] res_gamma
);

    localparam int unsigned CNT_W = $clog2(NOUT + 1);

    logic [NF-1:0][CNT_W-1:0] beat_cnt;
    logic [NF-1:0][ACC_W-1:0] cand_tuple;
    logic [NF-1:0][ACC_W-1:0] best_tuple;

    evidence_beat_count #(.NOUT(NOUT), .CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .dut_fail (dut_fail),
        .ref_fail (ref_fail),
        .beat_cnt (beat_cnt)
    );

    evidence_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .beat_valid (beat_valid),
        .cand_end   (cand_end),
        .beat_cnt   (beat_cnt),
        .cand_tuple (cand_tuple)
    );

    evidence_select #(.ACC_W(ACC_W), .ID_W(ID_W)) u_select (
        .clk        (clk),
        .rst        (rst),
        .cand_end   (cand_end),
        .cand_last  (cand_last),
        .cand_id    (cand_id),
        .cand_tuple (cand_tuple),
        .res_valid  (res_valid),
        .best_id    (res_id),
        .best_tuple (best_tuple)
    );

    assign res_sigma = best_tuple[IX_SIG];
    assign res_iota  = best_tuple[IX_IOT];
    assign res_tau   = best_tuple[IX_TAU];
    assign res_gamma = best_tuple[IX_GAM];

endmodule

// File: tb/sim_evidence_ranker.sv
module sim_evidence_ranker;

    localparam int NOUT  = 8;
    localparam int ACC_W = 6;
    localparam int ID_W  = 8;
    localparam int SATV  = 63;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst;
    logic             beat_valid;
    logic [NOUT-1:0]  dut_fail, ref_fail;
    logic             cand_end, cand_last;
    logic [ID_W-1:0]  cand_id;
    logic             res_valid;
    logic [ID_W-1:0]  res_id;
    logic [ACC_W-1:0] res_sigma, res_iota, res_tau, res_gamma;

    evidence_ranker #(.NOUT(NOUT), .ACC_W(ACC_W), .ID_W(ID_W)) u0 (
        .clk(clk), .rst(rst), .beat_valid(beat_valid), .dut_fail(dut_fail),
        .ref_fail(ref_fail), .cand_end(cand_end), .cand_id(cand_id),
        .cand_last(cand_last), .res_valid(res_valid), .res_id(res_id),
        .res_sigma(res_sigma), .res_iota(res_iota), .res_tau(res_tau),
        .res_gamma(res_gamma)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    // model state: index 0 sigma, 1 iota, 2 tau, 3 gamma
    int m_acc[4];
    int m_best[4];
    int m_best_id;
    bit m_have;

    function automatic int pop8(input logic [7:0] v);
        int n = 0;
        for (int k = 0; k < 8; k++) n += int'(v[k]);
        return n;
    endfunction

    function automatic bit bench_wins(input int cg, input int cs, input int ci,
                                      input int bg, input int bs, input int bi);
        if (cg != bg) return cg < bg;
        if (cs != bs) return cs > bs;
        return ci < bi;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_beat(input logic [7:0] d, input logic [7:0] r);
        int add[4];
        add[0] = pop8(d & r);
        add[1] = pop8(r & ~d);
        add[2] = pop8(d & ~r);
        add[3] = (add[1] > add[2]) ? add[1] : add[2];
        for (int f = 0; f < 4; f++) begin
            m_acc[f] += add[f];
            if (m_acc[f] > SATV) m_acc[f] = SATV;
        end
    endtask

    task automatic check_result(input string id_tag);
        chk("R10 res_valid pulse", int'(res_valid), 1);
        chk(id_tag, int'(res_id), m_best_id);
        chk("R1 sigma", int'(res_sigma), m_best[0]);
        chk("R2 iota", int'(res_iota), m_best[1]);
        chk("R3 tau", int'(res_tau), m_best[2]);
        chk("R4 gamma", int'(res_gamma), m_best[3]);
    endtask

    task automatic beat(input logic [7:0] d, input logic [7:0] r);
        model_beat(d, r);
        beat_valid = 1'b1; dut_fail = d; ref_fail = r;
        @(posedge clk); #1;
        beat_valid = 1'b0; dut_fail = '0; ref_fail = '0;
    endtask

    task automatic end_cand(input int id, input bit last, input bit wb,
                            input logic [7:0] d, input logic [7:0] r,
                            input string id_tag);
        if (wb) model_beat(d, r);
        if (!m_have || bench_wins(m_acc[3], m_acc[0], m_acc[1], m_best[3], m_best[0], m_best[1])) begin
            for (int f = 0; f < 4; f++) m_best[f] = m_acc[f];
            m_best_id = id;
        end
        m_have = 1'b1;
        for (int f = 0; f < 4; f++) m_acc[f] = 0;
        cand_end = 1'b1; cand_id = ID_W'(id); cand_last = last;
        beat_valid = wb; dut_fail = wb ? d : '0; ref_fail = wb ? r : '0;
        @(posedge clk); #1;
        cand_end = 1'b0; cand_last = 1'b0; beat_valid = 1'b0;
        dut_fail = '0; ref_fail = '0;
        if (last) begin
            check_result(id_tag);
            m_have = 1'b0;
            @(posedge clk); #1;
            chk("R10 pulse one cycle", int'(res_valid), 0);
        end
    endtask

    task automatic t_reset();
        chk("R13 reset res_valid", int'(res_valid), 0);
        chk("R13 reset res_id", int'(res_id), 0);
        chk("R13 reset res_sigma", int'(res_sigma), 0);
        chk("R13 reset res_gamma", int'(res_gamma), 0);
    endtask

    task automatic t_counts();
        beat(8'hF0, 8'hCC);
        beat(8'hFF, 8'h00);
        beat(8'h00, 8'h0F);
        chk("R10 no pulse mid-set", int'(res_valid), 0);
        beat(8'hAA, 8'hAA);
        beat(8'h81, 8'h18);
        end_cand(3, 1, 0, 8'h00, 8'h00, "R1 counts id");
    endtask

    task automatic t_gamma();
        beat(8'hFF, 8'h00); end_cand(1, 0, 0, 8'h00, 8'h00, "R6");
        beat(8'h01, 8'h00); end_cand(2, 0, 0, 8'h00, 8'h00, "R6");
        beat(8'h0F, 8'h00); end_cand(4, 1, 0, 8'h00, 8'h00, "R6 lowest gamma id");
        chk("R6 winner is 2", int'(res_id), 2);
    endtask

    task automatic t_sigma();
        beat(8'h03, 8'h01); end_cand(10, 0, 0, 8'h00, 8'h00, "R7");
        beat(8'h07, 8'h03); end_cand(11, 0, 0, 8'h00, 8'h00, "R7");
        beat(8'h01, 8'h03); end_cand(12, 1, 0, 8'h00, 8'h00, "R7 highest sigma id");
        chk("R7 winner is 11", int'(res_id), 11);
    endtask

    task automatic t_iota();
        beat(8'h01, 8'h03); end_cand(20, 0, 0, 8'h00, 8'h00, "R8");
        beat(8'h03, 8'h01); end_cand(21, 1, 0, 8'h00, 8'h00, "R8 lowest iota id");
        chk("R8 winner is 21", int'(res_id), 21);
    endtask

    task automatic t_tie();
        beat(8'h0F, 8'h0F); end_cand(30, 0, 0, 8'h00, 8'h00, "R9");
        beat(8'h0F, 8'h0F); end_cand(31, 0, 0, 8'h00, 8'h00, "R9");
        beat(8'h0F, 8'h0F); end_cand(32, 1, 0, 8'h00, 8'h00, "R9 earliest kept id");
        chk("R9 winner is 30", int'(res_id), 30);
    endtask

    task automatic t_sat();
        for (int n = 0; n < 10; n++) beat(8'hFF, 8'hFF);
        end_cand(40, 0, 0, 8'h00, 8'h00, "R5");
        beat(8'hFF, 8'h00);
        end_cand(41, 1, 0, 8'h00, 8'h00, "R5 id");
        chk("R5 sigma saturated", int'(res_sigma), SATV);
    endtask

    task automatic t_end_beat();
        beat(8'h00, 8'h00);
        end_cand(50, 0, 1, 8'hFF, 8'h00, "R11");
        end_cand(51, 1, 1, 8'h01, 8'h00, "R11 end-beat id");
        chk("R11 tau restarted", int'(res_tau), 1);
        chk("R11 winner is 51", int'(res_id), 51);
    endtask

    task automatic t_fresh();
        beat(8'h0F, 8'h0F); end_cand(60, 1, 0, 8'h00, 8'h00, "R12 set A id");
        beat(8'hFF, 8'h00); end_cand(61, 1, 0, 8'h00, 8'h00, "R12 set B id");
        chk("R12 worse candidate taken", int'(res_gamma), 8);
    endtask

    initial begin
        rst = 1'b1; beat_valid = 1'b0; dut_fail = '0; ref_fail = '0;
        cand_end = 1'b0; cand_id = '0; cand_last = 1'b0;
        m_have = 1'b0; m_best_id = 0;
        for (int f = 0; f < 4; f++) begin m_acc[f] = 0; m_best[f] = 0; end
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst = 1'b0;
        t_counts();
        t_gamma();
        t_sigma();
        t_iota();
        t_tie();
        t_sat();
        t_end_beat();
        t_fresh();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule